// File: doc/BRIEF.md
# Gated Event Counter with Internal PWM Gate

This block counts rising edges on an asynchronous event input with a 16-bit counter. Counting is allowed only while a gate is high. The gate comes from one of two places. It can be an external gate pin, or it can be the output of a PWM generator inside the block. A control bit picks the source.

The PWM generator runs on a time base that divides the system clock by 2, 4, 8, 16, 32 or 64. Each PWM cycle starts with an off phase and ends with an on phase. Two 16-bit registers set the cycle: the period value P and the off value O. When the PWM feeds the gate, the counter only sees events inside the on window. This lets software measure event rates over a fixed, repeating interval.

All configuration goes through a small synchronous write port:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit 0 enables the PWM, bit 1 picks the gate source, bits 4:2 pick the divider |
| 1 | Period | P |
| 2 | Off time | O |
| 3 | Clear | any write clears the counter |

Top module: `gated_event_counter`

## Requirements
- R1: Control field bits 4:2 (sel) set the PWM time base to one tick every 2^(sel+1) system clocks for sel 0..5. Codes 6 and 7 behave as a division by 64.
- R2: With the PWM enabled, one full cycle (one low run plus one high run) lasts (P+1) ticks.
- R3: Each PWM cycle is low for (O+1) ticks first, then high for (P-O) ticks, when O < P.
- R4: When O >= P, the PWM output stays low for as long as both values are in force.
- R5: While control bit 0 is 0, the PWM output is low and the prescaler and PWM counters are cleared. After bit 0 is set, the first rise of the output comes exactly (O+1)*2^(sel+1) clocks after the write edge.
- R6: A new P or O that is written during a cycle leaves the rest of that cycle unchanged. It applies from the next cycle start, which is the fall of the high phase.
- R7: With control bit 1 = 0, each rising edge of the event input is counted while the external gate is high. No edge is counted while the gate is low.
- R8: With control bit 1 = 1, the PWM output is the gate and the external gate pin has no effect.
- R9: The counter wraps from 0xFFFF to 0x0000 on the next counted edge.
- R10: A write to address 3 clears the counter to 0. If a clear and a counted edge fall on the same clock, the clear wins.
- R11: After reset, the counter reads 0, the PWM output is low and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 1 | Asynchronous event input, counted on rising edges |
| gate_in | input | 1 | Asynchronous external gate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Event counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The PWM is tried with random (P, O, sel) triples, including the out-of-range divider codes. Measuring the length of every steady low run and high run shows whether the off and on ticks are counted correctly and whether the divider is right. Directed cases cover:
- a period change made in the middle of the on phase, which shows whether the new value is taken immediately or at the cycle boundary;
- O >= P, and disabling and re-enabling the PWM, which checks the restart timing exactly.

Event streams with random pulse widths are sent with the external gate high and then low, and with the PWM as the gate. This separates gate-source selection from plain edge counting. A long run of minimum-width pulses takes the counter through its wrap.

// File: rtl/gec_pkg.sv
`timescale 1ns/1ps
package gec_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL    = 2'd0,
    ADR_PERIOD  = 2'd1,
    ADR_OFFTIME = 2'd2,
    ADR_CLEAR   = 2'd3
  } gec_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_GSEL_BIT = 1;
  localparam int CTRL_PSEL_LSB = 2;
endpackage

// File: rtl/gec_sync.sv
`timescale 1ns/1ps
module gec_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gec_timebase.sv
`timescale 1ns/1ps
module gec_timebase #(
  parameter int PRE_W  = 6,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam logic [PSEL_W-1:0] SEL_MAX = PSEL_W'(PRE_W - 1);

  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  mask;
  logic [PSEL_W-1:0] sel_eff;

  always_comb begin
    sel_eff = (psel > SEL_MAX) ? SEL_MAX : psel;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(sel_eff));
  end

  assign tick = en && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) pre_cnt <= '0;
    else            pre_cnt <= pre_cnt + 1'b1;
  end

  // the divider is at least 2, so two ticks are never adjacent
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/gec_pwm.sv
`timescale 1ns/1ps
module gec_pwm #(
  parameter int PWM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [PWM_W-1:0] per_reg,
  input  logic [PWM_W-1:0] off_reg,
  output logic             pwm_q
);
  logic [PWM_W-1:0] pcnt, pcnt_nxt;
  logic [PWM_W-1:0] act_per, act_off, per_nxt, off_nxt;
  logic             wrap, load, on_nxt;

  always_comb begin
    wrap     = tick && (pcnt == act_per);
    load     = !en || wrap;
    per_nxt  = load ? per_reg : act_per;
    off_nxt  = load ? off_reg : act_off;
    if (!en)      pcnt_nxt = '0;
    else if (wrap) pcnt_nxt = '0;
    else if (tick) pcnt_nxt = pcnt + 1'b1;
    else           pcnt_nxt = pcnt;
    on_nxt   = en && (pcnt_nxt > off_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      act_per <= '1;
      act_off <= '1;
      pwm_q   <= 1'b0;
    end else begin
      pcnt    <= pcnt_nxt;
      act_per <= per_nxt;
      act_off <= off_nxt;
      pwm_q   <= on_nxt;
    end
  end

  p_pcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pcnt <= act_per);

  p_on_after_off_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> (pcnt == act_off + 1'b1));

  p_const_low_r4: assert property (@(posedge clk) disable iff (rst)
    (act_off >= act_per && off_reg >= per_reg) |=> !pwm_q);

  p_off_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_q && pcnt == '0));
endmodule

// File: rtl/gec_evcnt.sv
`timescale 1ns/1ps
module gec_evcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_s,
  input  logic             gate_ext_s,
  input  logic             pwm,
  input  logic             gsel,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  logic ev_d, rise, gate;

  assign rise = ev_s && !ev_d;
  assign gate = gsel ? pwm : gate_ext_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_d  <= 1'b0;
      count <= '0;
    end else begin
      ev_d <= ev_s;
      if (clr)              count <= '0;
      else if (rise && gate) count <= count + 1'b1;
    end
  end

  p_gate_low_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !gate) |=> (count == $past(count)));

  p_single_step_r9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/gated_event_counter.sv
`timescale 1ns/1ps
module gated_event_counter
  import gec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PWM_W  = 16,
  parameter int PRE_W  = 6,
  parameter int PSEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_in,
  input  logic             gate_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [PWM_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_o
);
  localparam int PSEL_MSB = CTRL_PSEL_LSB + PSEL_W - 1;

  logic              ctl_en, ctl_gsel;
  logic [PSEL_W-1:0] ctl_psel;
  logic [PWM_W-1:0]  per_reg, off_reg;
  logic              clr, tick, ev_s, gate_s, pwm_q;
  logic [1:0]        sync_q;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data[PWM_W-1:PSEL_MSB+1];
  assign clr = wr_en && (gec_addr_e'(wr_addr) == ADR_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      ctl_gsel <= 1'b0;
      ctl_psel <= '0;
      per_reg  <= '1;
      off_reg  <= '1;
    end else if (wr_en) begin
      case (gec_addr_e'(wr_addr))
        ADR_CTRL: begin
          ctl_en   <= wr_data[CTRL_EN_BIT];
          ctl_gsel <= wr_data[CTRL_GSEL_BIT];
          ctl_psel <= wr_data[PSEL_MSB:CTRL_PSEL_LSB];
        end
        ADR_PERIOD:  per_reg <= wr_data;
        ADR_OFFTIME: off_reg <= wr_data;
        default: ;
      endcase
    end
  end

  gec_sync #(.W(2), .STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .d({gate_in, event_in}), .q(sync_q)
  );
  assign ev_s   = sync_q[0];
  assign gate_s = sync_q[1];

  gec_timebase #(.PRE_W(PRE_W), .PSEL_W(PSEL_W)) i_timebase (
    .clk(clk), .rst(rst), .en(ctl_en), .psel(ctl_psel), .tick(tick)
  );

  gec_pwm #(.PWM_W(PWM_W)) i_pwm (
    .clk(clk), .rst(rst), .en(ctl_en), .tick(tick),
    .per_reg(per_reg), .off_reg(off_reg), .pwm_q(pwm_q)
  );

  gec_evcnt #(.CNT_W(CNT_W)) i_evcnt (
    .clk(clk), .rst(rst), .ev_s(ev_s), .gate_ext_s(gate_s), .pwm(pwm_q),
    .gsel(ctl_gsel), .clr(clr), .count(count_o)
  );

  assign pwm_o = pwm_q;

  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !pwm_o && !ctl_en && !ctl_gsel));
endmodule

// File: tb/test_gated_event_counter.sv
`timescale 1ns/1ps
module test_gated_event_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        event_in = 1'b0, gate_in = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        pwm_o;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  int run_len = 0, last_hi = 0, last_lo = 0, n_hi = 0, n_lo = 0;
  logic prev = 1'b0;

  always #2 clk = ~clk;

  gated_event_counter i_gated_event_counter (
    .clk(clk), .rst(rst), .event_in(event_in), .gate_in(gate_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .pwm_o(pwm_o)
  );

  function automatic int f_div(int sel);
    return (sel > 5) ? 64 : (2 << sel);
  endfunction
  function automatic int f_lo(int o, int sel);
    return (o + 1) * f_div(sel);
  endfunction
  function automatic int f_hi(int p, int o, int sel);
    return (p - o) * f_div(sel);
  endfunction
  function automatic logic [15:0] f_ctrl(bit en, bit gsel, int sel);
    return 16'((sel << 2) | (int'(gsel) << 1) | int'(en));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      int hi = rnd ? 1 + int'($urandom_range(3)) : 1;
      int lo = rnd ? 1 + int'($urandom_range(3)) : 1;
      event_in = 1'b1;
      repeat (hi) @(negedge clk);
      event_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_lo_end();
    int c = n_lo;
    wait (n_lo != c);
  endtask
  task automatic wait_hi_end();
    int c = n_hi;
    wait (n_hi != c);
  endtask

  // run-length tracker for the PWM output
  always @(negedge clk) begin
    if (rst) begin
      prev = 1'b0; run_len = 0;
    end else if (pwm_o == prev) begin
      run_len++;
    end else begin
      if (prev) begin last_hi = run_len; n_hi++; end
      else      begin last_lo = run_len; n_lo++; end
      run_len = 1;
      prev = pwm_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(count_o == 16'd0, "R11 count", int'(count_o), 0);
    chk(pwm_o == 1'b0, "R11 pwm", int'(pwm_o), 0);

    // R1/R2/R3: random PWM configurations
    for (int t = 0; t < 8; t++) begin
      int p = 1 + int'($urandom_range(14));
      int o = int'($urandom_range(p - 1));
      int s = (t == 7) ? 7 : ((t == 6) ? 6 : int'($urandom_range(5)));
      wr(2'd0, f_ctrl(0, 0, s));
      wr(2'd1, 16'(p));
      wr(2'd2, 16'(o));
      wr(2'd0, f_ctrl(1, 0, s));
      wait_lo_end();
      wait_hi_end();
      chk(last_hi == f_hi(p, o, s), "R3 high run", last_hi, f_hi(p, o, s));
      wait_lo_end();
      chk(last_lo == f_lo(o, s), "R1 low run", last_lo, f_lo(o, s));
      chk(last_hi + last_lo == (p + 1) * f_div(s), "R2 period",
          last_hi + last_lo, (p + 1) * f_div(s));
    end

    // R6: period change mid-cycle
    wr(2'd0, f_ctrl(0, 0, 0));
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd4);
    wr(2'd0, f_ctrl(1, 0, 0));
    wait_lo_end();
    wr(2'd1, 16'd19);
    wait_hi_end();
    chk(last_hi == 10, "R6 old high kept", last_hi, 10);
    wait_lo_end();
    chk(last_lo == 10, "R6 low", last_lo, 10);
    wait_hi_end();
    chk(last_hi == 30, "R6 new high", last_hi, 30);

    // R5: disable holds low, re-enable restarts exactly
    begin
      int seen = 0, c = 0;
      wr(2'd0, f_ctrl(0, 0, 1));
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pwm_o) seen++;
      end
      chk(seen == 0, "R5 low while disabled", seen, 0);
      wr(2'd1, 16'd5);
      wr(2'd2, 16'd2);
      wr(2'd0, f_ctrl(1, 0, 1));
      while (pwm_o == 1'b0 && c < 1000) begin
        @(negedge clk); c++;
      end
      chk(c == f_lo(2, 1), "R5 restart delay", c, f_lo(2, 1));
    end

    // R4: off >= period gives constant low
    begin
      int seen = 0;
      wr(2'd1, 16'd3);
      wr(2'd2, 16'd3);
      repeat (40) @(negedge clk);
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (pwm_o) seen++;
      end
      chk(seen == 0, "R4 constant low", seen, 0);
      wr(2'd0, f_ctrl(1, 1, 0));
      gate_in = 1'b1;
      repeat (4) @(negedge clk);
      pulses(12, 1);
      chk(int'(count_o) == exp_cnt, "R4 no count with low pwm gate",
          int'(count_o), exp_cnt);
    end

    // R7: external gate high counts, low ignores
    wr(2'd0, f_ctrl(0, 0, 0));
    for (int t = 0; t < 4; t++) begin
      int n = 1 + int'($urandom_range(49));
      gate_in = 1'b1;
      repeat (4) @(negedge clk);
      pulses(n, 1);
      exp_cnt += n;
      chk(int'(count_o) == exp_cnt, "R7 gate high", int'(count_o), exp_cnt);
      gate_in = 1'b0;
      repeat (4) @(negedge clk);
      pulses(n, 1);
      chk(int'(count_o) == exp_cnt, "R7 gate low", int'(count_o), exp_cnt);
    end

    // R8: PWM as gate, external pin ignored
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'd0);
    wr(2'd0, f_ctrl(1, 1, 0));
    gate_in = 1'b0;
    repeat (20) @(negedge clk);
    chk(pwm_o == 1'b1, "R8 pwm on", int'(pwm_o), 1);
    pulses(37, 1);
    exp_cnt += 37;
    chk(int'(count_o) == exp_cnt, "R8 pwm gate open", int'(count_o), exp_cnt);
    wr(2'd0, f_ctrl(0, 1, 0));
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
    pulses(10, 1);
    chk(int'(count_o) == exp_cnt, "R8 ext pin ignored", int'(count_o), exp_cnt);

    // R10: clear
    wr(2'd3, 16'd0);
    exp_cnt = 0;
    @(negedge clk);
    chk(count_o == 16'd0, "R10 clear", int'(count_o), 0);

    // R9: wrap
    wr(2'd0, f_ctrl(0, 0, 0));
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
    pulses(65535, 0);
    chk(count_o == 16'hFFFF, "R9 full", int'(count_o), 65535);
    pulses(1, 0);
    chk(count_o == 16'h0000, "R9 wrap", int'(count_o), 0);
    pulses(3, 0);
    chk(count_o == 16'd3, "R9 after wrap", int'(count_o), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule